// File: doc/BRIEF.md
# ATA Device Probe and Soft Reset Sequencer

This block runs the bus bring-up sequence of a parallel ATA host port. On a start pulse it checks which of the two devices on the cable answer register writes. For each device it selects the device and writes an alternating test pattern into the sector count and LBA low registers. It then reads both registers back. Device 1 is only checked when the caller says a slave can exist. After the check, device 0 is selected again and the sequencer pulses the software-reset bit of the device control register. The two writes around the pulse are spaced by a timed gap.

After the reset it waits a fixed settle time and asks an external ready poller to wait for device 0. If device 1 was found, it selects device 1 and gives that device a bounded number of tries to show its post-reset register values. Tries are separated by a long pause, and then device 1 is also waited on. The sequence ends by writing device selects in a set order. The block reports a two-bit presence mask and a two-bit result code.

Every register access goes through a request/acknowledge port to a PIO cycle engine that is outside this block. All delays are counted in clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `ata_probe_sequencer`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `reg_req` and `rdy_req` are 0, and `dev_mask` and `result` are 0.
- R2: A device is selected by a write to register address 6 with data 0xA0 for device 0 or 0xB0 for device 1 (bit 4 picks the device).
- R3: Each check writes, in this order, sector count (address 2) 0x55, LBA low (address 3) 0xAA, sector count 0xAA, LBA low 0x55, sector count 0x55, LBA low 0xAA. It then reads address 2 and then address 3. The device's `dev_mask` bit is set only if the two reads return 0x55 and 0xAA.
- R4: Device 1 is checked only if `slave_possible` was 1 in the cycle `start` was taken; later changes of that input have no effect on the run. Device 0 is selected again before the reset.
- R5: The reset writes the control register (address 0xE) three times: CTL_BASE, then CTL_BASE|0x04, then CTL_BASE. Each of the two gaps lasts at least SRST_US×CYC_PER_US cycles.
- R6: At least SETTLE_US×CYC_PER_US cycles after the last control write, a ready wait for device 0 is requested (`rdy_req`=1, `rdy_dev`=0). Any `rdy_code` other than 0 ends the run with result 2 and no further register accesses.
- R7: If device 1 is present, it is selected and then gets up to two tries of reading address 2 and then address 3. Tries stop early when both reads return 0x01. Each failed try is followed by a pause of at least RETRY_US×CYC_PER_US cycles. After that a ready wait for device 1 is requested (`rdy_dev`=1).
- R8: A device 1 ready wait with `rdy_code` 1 (no device) gives result 1 and the sequence continues. A code of 2 or 3 gives result 3 and ends the run at once. Result 0 means success.
- R9: The run ends by selecting device 0, then device 1 if its mask bit is set, then device 0 if its mask bit is set.
- R10: A register request holds `reg_we`, `reg_addr` and `reg_wdata` steady until the cycle `reg_ack` is 1. A ready request holds until `rdy_done` is 1. Only one of `reg_req` and `rdy_req` is high at a time.
- R11: `start` is ignored while `busy` is 1. `done` is a single-cycle pulse. `dev_mask` and `result` stay unchanged from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe and reset run (taken when idle) |
| slave_possible | input | 1 | Device 1 may exist on the cable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| dev_mask | output | 2 | Bit n set when device n passed the pattern check |
| result | output | 2 | 0 ok, 1 slave absent warning, 2 master not ready, 3 slave not ready |
| reg_req | output | 1 | Register access request to the PIO engine |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | 4 | Bit 3 selects control block, bits 2:0 register index |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete (read data valid) |
| reg_rdata | input | 8 | Read data |
| rdy_req | output | 1 | Request a wait for the device to clear BSY |
| rdy_dev | output | 1 | Device being waited on |
| rdy_done | input | 1 | Ready wait finished |
| rdy_code | input | 2 | 0 ready, 1 no device, 2 or 3 timeout |

## Verification
A `start` pulse can arrive in the same cycle that the sequencer is working through the probe, moving from one access to the next. The bench makes this happen by pulsing `start` and flipping `slave_possible` partway through a run. It then judges the full logged access sequence against one computed from the scenario as it was when the run began. The other overlap is an engine acknowledge in the very cycle a new request first appears. Random zero-cycle acknowledge latencies produce this, and the bench confirms that no access is lost or repeated and that the timed gaps still meet their minimums.

// File: rtl/aps_pkg.sv
package aps_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_PRESEL, S_RST, S_SETTLE, S_WMST,
    S_SEL1, S_CHK, S_RETRY, S_WSLV, S_FIN, S_DONE
  } seq_state_e;

  // register addresses seen by the PIO engine: {control block, index}
  localparam logic [3:0] ADR_NSECT  = 4'h2;
  localparam logic [3:0] ADR_LBAL   = 4'h3;
  localparam logic [3:0] ADR_DEVSEL = 4'h6;
  localparam logic [3:0] ADR_DEVCTL = 4'hE;

  localparam logic [7:0] SEL_BASE   = 8'hA0;
  localparam logic [7:0] SEL_DEV1   = 8'h10;
  localparam logic [7:0] CTL_SRST   = 8'h04;
  localparam logic [7:0] PAT_LO     = 8'h55;
  localparam logic [7:0] PAT_HI     = 8'hAA;
  localparam logic [7:0] SIG_ONE    = 8'h01;

  localparam logic [1:0] RDY_OK     = 2'd0;
  localparam logic [1:0] RDY_NODEV  = 2'd1;

  localparam logic [1:0] RES_OK         = 2'd0;
  localparam logic [1:0] RES_WARN_NODEV = 2'd1;
  localparam logic [1:0] RES_ERR_MASTER = 2'd2;
  localparam logic [1:0] RES_ERR_SLAVE  = 2'd3;

endpackage

// File: rtl/aps_timer.sv
module aps_timer #(
  parameter int CYC_PER_US = 100,
  parameter int US_W       = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            fire
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(CYC_PER_US - 1);

  logic            run_q, run_n;
  logic [PW-1:0]   pre_q, pre_n;
  logic [US_W-1:0] us_q, us_n;
  logic            fire_q, fire_n;

  always_comb begin
    run_n  = run_q;
    pre_n  = pre_q;
    us_n   = us_q;
    fire_n = 1'b0;
    if (load) begin
      run_n = 1'b1;
      pre_n = PRE_TOP;
      us_n  = load_us;
    end else if (run_q) begin
      if (pre_q != '0) begin
        pre_n = pre_q - 1'b1;
      end else begin
        pre_n = PRE_TOP;
        if (us_q <= US_W'(1)) begin
          run_n  = 1'b0;
          fire_n = 1'b1;
        end else begin
          us_n = us_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      us_q   <= '0;
      fire_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      pre_q  <= pre_n;
      us_q   <= us_n;
      fire_q <= fire_n;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/aps_opdecode.sv
module aps_opdecode
  import aps_pkg::*;
#(
  parameter logic [7:0] CTL_BASE = 8'h08
) (
  input  seq_state_e  state,
  input  logic [3:0]  sub,
  input  logic        dev,
  output logic        reg_req,
  output logic        reg_we,
  output logic [3:0]  reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        rdy_req,
  output logic        rdy_dev
);
  logic [3:0] pair;
  logic       to_lbal;

  always_comb begin
    reg_req   = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = ADR_DEVSEL;
    reg_wdata = 8'h00;
    rdy_req   = 1'b0;
    rdy_dev   = 1'b0;
    pair      = (sub + 4'd1) >> 1;
    to_lbal   = ~sub[0];
    case (state)
      S_PROBE: begin
        reg_req = 1'b1;
        if (sub == 4'd0) begin
          reg_we    = 1'b1;
          reg_wdata = dev ? (SEL_BASE | SEL_DEV1) : SEL_BASE;
        end else if (sub <= 4'd6) begin
          reg_we    = 1'b1;
          reg_addr  = to_lbal ? ADR_LBAL : ADR_NSECT;
          reg_wdata = (pair[0] ^ to_lbal) ? PAT_LO : PAT_HI;
        end else begin
          reg_addr = (sub == 4'd7) ? ADR_NSECT : ADR_LBAL;
        end
      end
      S_PRESEL: begin
        reg_req   = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = SEL_BASE;
      end
      S_RST: begin
        reg_req   = ~sub[0];
        reg_we    = 1'b1;
        reg_addr  = ADR_DEVCTL;
        reg_wdata = (sub == 4'd2) ? (CTL_BASE | CTL_SRST) : CTL_BASE;
      end
      S_SEL1: begin
        reg_req   = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = SEL_BASE | SEL_DEV1;
      end
      S_CHK: begin
        reg_req  = 1'b1;
        reg_addr = (sub == 4'd0) ? ADR_NSECT : ADR_LBAL;
      end
      S_FIN: begin
        reg_req   = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = (sub == 4'd1) ? (SEL_BASE | SEL_DEV1) : SEL_BASE;
      end
      S_WMST: rdy_req = 1'b1;
      S_WSLV: begin
        rdy_req = 1'b1;
        rdy_dev = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ata_probe_sequencer.sv
module ata_probe_sequencer
  import aps_pkg::*;
#(
  parameter int         CYC_PER_US = 100,
  parameter int         SRST_US    = 20,
  parameter int         SETTLE_US  = 150000,
  parameter int         RETRY_US   = 50000,
  parameter logic [7:0] CTL_BASE   = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       slave_possible,
  output logic       busy,
  output logic       done,
  output logic [1:0] dev_mask,
  output logic [1:0] result,
  output logic       reg_req,
  output logic       reg_we,
  output logic [3:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic       reg_ack,
  input  logic [7:0] reg_rdata,
  output logic       rdy_req,
  output logic       rdy_dev,
  input  logic       rdy_done,
  input  logic [1:0] rdy_code
);
  localparam int MAX_A  = (SETTLE_US > RETRY_US) ? SETTLE_US : RETRY_US;
  localparam int MAX_US = (MAX_A > SRST_US) ? MAX_A : SRST_US;
  localparam int TW     = $clog2(MAX_US + 1);

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  seq_state_e state_q, state_n;
  logic [3:0] sub_q, sub_n;
  logic       dev_q, dev_n;
  logic [1:0] mask_q, mask_n;
  logic [1:0] res_q, res_n;
  logic       flag_q, flag_n;
  logic       try_q, try_n;
  logic       sp_q, sp_n;
  logic       tmr_load, tmr_fire;
  logic [TW-1:0] tmr_us;

  aps_timer #(.CYC_PER_US(CYC_PER_US), .US_W(TW)) timer_i (
    .clk(clk), .rst_n(rst_s_n), .load(tmr_load), .load_us(tmr_us), .fire(tmr_fire)
  );

  aps_opdecode #(.CTL_BASE(CTL_BASE)) dec_i (
    .state(state_q), .sub(sub_q), .dev(dev_q),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rdy_req(rdy_req), .rdy_dev(rdy_dev)
  );

  always_comb begin
    state_n  = state_q;
    sub_n    = sub_q;
    dev_n    = dev_q;
    mask_n   = mask_q;
    res_n    = res_q;
    flag_n   = flag_q;
    try_n    = try_q;
    sp_n     = sp_q;
    tmr_load = 1'b0;
    tmr_us   = '0;
    case (state_q)
      S_IDLE: if (start) begin
        state_n = S_PROBE;
        sub_n   = 4'd0;
        dev_n   = 1'b0;
        mask_n  = 2'b00;
        res_n   = RES_OK;
        sp_n    = slave_possible;
      end
      S_PROBE: if (reg_ack) begin
        if (sub_q == 4'd7) flag_n = (reg_rdata == PAT_LO);
        if (sub_q == 4'd8) begin
          mask_n[dev_q] = flag_q & (reg_rdata == PAT_HI);
          sub_n = 4'd0;
          if (!dev_q && sp_q) dev_n = 1'b1;
          else state_n = S_PRESEL;
        end else begin
          sub_n = sub_q + 4'd1;
        end
      end
      S_PRESEL: if (reg_ack) begin
        state_n = S_RST;
        sub_n   = 4'd0;
      end
      S_RST: begin
        if (sub_q[0]) begin
          if (tmr_fire) sub_n = sub_q + 4'd1;
        end else if (reg_ack) begin
          tmr_load = 1'b1;
          if (sub_q == 4'd4) begin
            state_n = S_SETTLE;
            tmr_us  = TW'(SETTLE_US);
          end else begin
            sub_n  = sub_q + 4'd1;
            tmr_us = TW'(SRST_US);
          end
        end
      end
      S_SETTLE: if (tmr_fire) state_n = S_WMST;
      S_WMST: if (rdy_done) begin
        sub_n = 4'd0;
        if (rdy_code != RDY_OK) begin
          res_n   = RES_ERR_MASTER;
          state_n = S_DONE;
        end else if (mask_q[1]) begin
          state_n = S_SEL1;
        end else begin
          state_n = S_FIN;
        end
      end
      S_SEL1: if (reg_ack) begin
        state_n = S_CHK;
        sub_n   = 4'd0;
        try_n   = 1'b0;
      end
      S_CHK: if (reg_ack) begin
        if (sub_q == 4'd0) begin
          flag_n = (reg_rdata == SIG_ONE);
          sub_n  = 4'd1;
        end else if (flag_q && reg_rdata == SIG_ONE) begin
          state_n = S_WSLV;
        end else begin
          state_n  = S_RETRY;
          tmr_load = 1'b1;
          tmr_us   = TW'(RETRY_US);
        end
      end
      S_RETRY: if (tmr_fire) begin
        if (try_q) begin
          state_n = S_WSLV;
        end else begin
          try_n   = 1'b1;
          state_n = S_CHK;
          sub_n   = 4'd0;
        end
      end
      S_WSLV: if (rdy_done) begin
        sub_n = 4'd0;
        if (rdy_code == RDY_OK) begin
          state_n = S_FIN;
        end else if (rdy_code == RDY_NODEV) begin
          res_n   = RES_WARN_NODEV;
          state_n = S_FIN;
        end else begin
          res_n   = RES_ERR_SLAVE;
          state_n = S_DONE;
        end
      end
      S_FIN: if (reg_ack) begin
        if (sub_q == 4'd0 && mask_q[1]) sub_n = 4'd1;
        else if (sub_q != 4'd2 && mask_q[0]) sub_n = 4'd2;
        else state_n = S_DONE;
      end
      S_DONE: state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE;
      sub_q   <= '0;
      dev_q   <= 1'b0;
      mask_q  <= '0;
      res_q   <= RES_OK;
      flag_q  <= 1'b0;
      try_q   <= 1'b0;
      sp_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      sub_q   <= sub_n;
      dev_q   <= dev_n;
      mask_q  <= mask_n;
      res_q   <= res_n;
      flag_q  <= flag_n;
      try_q   <= try_n;
      sp_q    <= sp_n;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign dev_mask = mask_q;
  assign result   = res_q;
endmodule

// File: rtl/aps_checker.sv
module aps_checker
  import aps_pkg::*;
#(
  parameter logic [7:0] CTL_BASE = 8'h08
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] dev_mask,
  input logic [1:0] result,
  input logic       reg_req,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_ack,
  input logic       rdy_req,
  input logic       rdy_dev,
  input logic       rdy_done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_req && !rdy_req)); // R1
  AST_DEVSEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADR_DEVSEL) |->
    (reg_wdata == SEL_BASE || reg_wdata == (SEL_BASE | SEL_DEV1))); // R2
  AST_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we) |-> (reg_addr == ADR_NSECT || reg_addr == ADR_LBAL)); // R3
  AST_CTL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADR_DEVCTL) |->
    ((reg_wdata & ~CTL_SRST) == CTL_BASE)); // R5
  AST_SLAVE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dev_mask[1]) |-> (result == RES_OK || result == RES_ERR_MASTER)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr)
                               && $stable(reg_wdata))); // R10
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_req && !rdy_done) |=> (rdy_req && $stable(rdy_dev))); // R10
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && rdy_req)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_HELD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(dev_mask) && $stable(result))); // R11
endmodule

bind ata_probe_sequencer aps_checker #(.CTL_BASE(CTL_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .dev_mask(dev_mask), .result(result), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
  .rdy_req(rdy_req), .rdy_dev(rdy_dev), .rdy_done(rdy_done)
);

// File: tb/ata_probe_sequencer_tb_top.sv
module ata_probe_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int SRST_US    = 5;
  localparam int SETTLE_US  = 40;
  localparam int RETRY_US   = 30;
  localparam logic [7:0] CTL_BASE = 8'h08;

  logic clk, rst_n, start, slave_possible;
  logic busy, done, reg_req, reg_we, reg_ack, rdy_req, rdy_dev, rdy_done;
  logic [1:0] dev_mask, result, rdy_code;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  ata_probe_sequencer #(.CYC_PER_US(CPU), .SRST_US(SRST_US), .SETTLE_US(SETTLE_US),
                        .RETRY_US(RETRY_US), .CTL_BASE(CTL_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .slave_possible(slave_possible),
    .busy(busy), .done(done), .dev_mask(dev_mask), .result(result),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .rdy_req(rdy_req), .rdy_dev(rdy_dev),
    .rdy_done(rdy_done), .rdy_code(rdy_code)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // scenario: device kind 0 absent, 1 present, 2 LBA low stuck at 0
  int sc_p0, sc_p1, sc_mc, sc_sc, sc_st;
  logic m_sel, m_post;
  logic [7:0] m_ns [2];
  logic [7:0] m_lb [2];
  int m_pair;

  logic [13:0] log_e [64];
  int          log_t [64];
  int          log_n;
  logic [13:0] exp_e [64];
  int          exp_lo [64];
  string       exp_tag [64];
  int          exp_n;
  logic [1:0]  exp_mask, exp_res;

  function automatic logic [13:0] enc(input logic w, input logic we,
                                      input logic [3:0] a, input logic [7:0] d);
    return {w, we, a, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [13:0] e, input string tag, input int lo);
    exp_e[exp_n] = e; exp_tag[exp_n] = tag; exp_lo[exp_n] = lo; exp_n++;
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    int k;
    if (m_post && m_sel) return (m_pair >= sc_st) ? 8'h01 : 8'h7F;
    k = m_sel ? sc_p1 : sc_p0;
    if (k == 0) return 8'hFF;
    if (a == 4'h2) return m_ns[m_sel];
    return (k == 1) ? m_lb[m_sel] : 8'h00;
  endfunction

  // PIO engine and ready poller model
  initial begin
    int lat_r, lat_w;
    reg_ack = 0; reg_rdata = 0; rdy_done = 0; rdy_code = 0;
    lat_r = 0; lat_w = 0;
    forever begin
      @(negedge clk);
      if (reg_ack) reg_ack = 0;
      else if (reg_req) begin
        if (lat_r > 0) lat_r--;
        else begin
          if (log_n < 64) begin log_t[log_n] = cyc; end
          if (reg_we) begin
            if (log_n < 64) log_e[log_n] = enc(0, 1, reg_addr, reg_wdata);
            case (reg_addr)
              4'h6: m_sel = reg_wdata[4];
              4'hE: if (reg_wdata[2]) begin m_post = 1; m_pair = 0; end
              4'h2: m_ns[m_sel] = reg_wdata;
              4'h3: m_lb[m_sel] = reg_wdata;
              default: ;
            endcase
          end else begin
            if (log_n < 64) log_e[log_n] = enc(0, 0, reg_addr, 8'h00);
            reg_rdata = model_read(reg_addr);
            if (reg_addr == 4'h3 && m_post) m_pair++;
          end
          log_n++;
          reg_ack = 1;
          lat_r = $urandom % 4;
        end
      end
      if (rdy_done) rdy_done = 0;
      else if (rdy_req) begin
        if (lat_w > 0) lat_w--;
        else begin
          if (log_n < 64) begin
            log_t[log_n] = cyc;
            log_e[log_n] = enc(1, 0, 4'h0, {7'd0, rdy_dev});
          end
          log_n++;
          rdy_code = rdy_dev ? sc_sc[1:0] : sc_mc[1:0];
          rdy_done = 1;
          lat_w = $urandom % 6;
        end
      end
    end
  end

  task automatic build_exp(input bit sp);
    bit m0, m1;
    exp_n = 0;
    m0 = (sc_p0 == 1); m1 = sp && (sc_p1 == 1);
    exp_mask = {m1, m0}; exp_res = 2'd0;
    for (int d = 0; d < (sp ? 2 : 1); d++) begin
      push(enc(0, 1, 4'h6, d ? 8'hB0 : 8'hA0), "R2", 0);
      push(enc(0, 1, 4'h2, 8'h55), "R3", 0);
      push(enc(0, 1, 4'h3, 8'hAA), "R3", 0);
      push(enc(0, 1, 4'h2, 8'hAA), "R3", 0);
      push(enc(0, 1, 4'h3, 8'h55), "R3", 0);
      push(enc(0, 1, 4'h2, 8'h55), "R3", 0);
      push(enc(0, 1, 4'h3, 8'hAA), "R3", 0);
      push(enc(0, 0, 4'h2, 8'h00), "R3", 0);
      push(enc(0, 0, 4'h3, 8'h00), "R3", 0);
    end
    push(enc(0, 1, 4'h6, 8'hA0), "R4", 0);
    push(enc(0, 1, 4'hE, CTL_BASE), "R5", SRST_US * CPU);
    push(enc(0, 1, 4'hE, CTL_BASE | 8'h04), "R5", SRST_US * CPU);
    push(enc(0, 1, 4'hE, CTL_BASE), "R6", SETTLE_US * CPU);
    push(enc(1, 0, 4'h0, 8'h00), "R6", 0);
    if (sc_mc != 0) begin exp_res = 2'd2; return; end
    if (m1) begin
      push(enc(0, 1, 4'h6, 8'hB0), "R7", 0);
      for (int t = 0; t < 2; t++) begin
        push(enc(0, 0, 4'h2, 8'h00), "R7", 0);
        push(enc(0, 0, 4'h3, 8'h00), "R7", (sc_st > t) ? RETRY_US * CPU : 0);
        if (sc_st <= t) break;
      end
      push(enc(1, 0, 4'h0, 8'h01), "R7", 0);
      if (sc_sc == 1) exp_res = 2'd1;
      if (sc_sc >= 2) begin exp_res = 2'd3; return; end
    end
    push(enc(0, 1, 4'h6, 8'hA0), "R9", 0);
    if (m1) push(enc(0, 1, 4'h6, 8'hB0), "R9", 0);
    if (m0) push(enc(0, 1, 4'h6, 8'hA0), "R9", 0);
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_case(input bit sp, input int p0, input int p1, input int mc,
                          input int sc, input int st, input bit disturb);
    int wait_c;
    logic [1:0] hold_m, hold_r;
    sc_p0 = p0; sc_p1 = p1; sc_mc = mc; sc_sc = sc; sc_st = st;
    m_post = 0; m_pair = 0; m_sel = 0; log_n = 0;
    build_exp(sp);
    @(negedge clk);
    slave_possible = sp; start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (7) @(negedge clk);
      slave_possible = ~sp; start = 1;            // R4 R11: both ignored mid-run
      @(negedge clk);
      start = 0;
    end
    wait_c = 0;
    while (!done && wait_c < 6000) begin @(negedge clk); wait_c++; end
    if (!done) begin
      chk(0, "R11", "watchdog: run did not finish", wait_c, 6000);
      do_reset();
      return;
    end
    chk(dev_mask == exp_mask, "R3", "presence mask", dev_mask, exp_mask);
    chk(result == exp_res, "R8", "result code", result, exp_res);
    hold_m = dev_mask; hold_r = result;
    @(negedge clk);
    chk(!done && !busy, "R11", "done width / busy drop", {done, busy}, 0);
    repeat (6) @(negedge clk);
    chk(dev_mask == hold_m && result == hold_r, "R11", "result held after done",
        {dev_mask, result}, {hold_m, hold_r});
    chk(log_n == exp_n, "R10", "access count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_e[i] == exp_e[i], exp_tag[i], $sformatf("step %0d", i), log_e[i], exp_e[i]);
      if (exp_lo[i] > 0 && i + 1 < log_n) begin
        int gap;
        gap = log_t[i + 1] - log_t[i];
        chk(gap >= exp_lo[i] && gap <= exp_lo[i] + 16, exp_tag[i],
            $sformatf("gap after step %0d", i), gap, exp_lo[i]);
      end
    end
  endtask

  initial begin
    clk = 0; rst_n = 0; start = 0; slave_possible = 0;
    log_n = 0; m_post = 0; m_sel = 0; m_pair = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !reg_req && !rdy_req, "R1", "outputs in reset",
        {busy, done, reg_req, rdy_req}, 0);
    do_reset();
    chk(!busy && !reg_req && !rdy_req && dev_mask == 0 && result == 0, "R1",
        "idle after reset", {busy, reg_req, rdy_req, dev_mask, result}, 0);
    // directed corners
    run_case(1, 1, 1, 0, 0, 0, 0);  // both present, slave answers first try
    run_case(0, 1, 1, 0, 0, 0, 0);  // R4 slave not possible
    run_case(1, 1, 1, 2, 0, 0, 0);  // R6 master not ready
    run_case(1, 1, 1, 0, 1, 1, 0);  // R8 warning, R7 one retry
    run_case(1, 1, 1, 0, 2, 2, 0);  // R8 slave timeout after two failed tries
    run_case(1, 0, 1, 0, 0, 0, 0);  // R9 only slave present
    run_case(1, 2, 2, 0, 0, 0, 0);  // R3 LBA low stuck: neither present
    run_case(1, 1, 1, 0, 0, 1, 1);  // R11 start and slave_possible disturbed
    run_case(0, 1, 0, 0, 0, 0, 1);
    for (int k = 0; k < 24; k++) begin
      int mr;
      mr = $urandom % 6;
      run_case($urandom % 2, $urandom % 3, $urandom % 3, (mr >= 4) ? mr - 3 : 0,
               $urandom % 4, $urandom % 3, $urandom % 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_vec++; n_bad++;
    $display("FAIL R11 global watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule